// File: doc/BRIEF.md
# Serial Slave Port with Chip-Select Resynchronisation

This block is a serial slave port that sits behind a host processor. It runs entirely on a fast internal system clock. The host chip-select, serial clock and data-in lines are oversampled by that clock, and bytes move in both directions in SPI mode 0. The serial clock idles low. Incoming bits are captured on the rising serial-clock edge, and outgoing bits change after the falling edge. Bits travel most significant first.

The port keeps a byte counter that runs across chip-select frames. The first byte received after the counter is cleared is marked as a command byte, and every byte after it is marked as data. The counter is cleared by the block's reset. It is also cleared by a resynchronisation frame: chip-select is held low for at least two system clock cycles and then released with no rising serial-clock edge in between. The host sends such a frame whenever the slave may have been reinitialised in the middle of a transfer. This lets the host bring its byte framing back into line with the slave's.

Each received byte appears on a parallel output with a one-cycle strobe and a command/data flag. The byte to transmit is taken from a parallel input at the start of each byte time.

Top module: `spi_resync_slave`

## Requirements
- R1: After reset, `rx_valid` and `host_miso` are 0, and the byte counter is clear, so the first complete byte received is tagged as a command.
- R2: In a qualified frame, data-in is sampled at each rising serial-clock edge, MSB first. After the eighth rising edge, `rx_byte` carries the assembled byte and `rx_valid` is 1 for exactly one system clock cycle.
- R3: While chip-select is low, `host_miso` shows bit 7 of the transmit byte before the first rising edge of a byte. It moves to the next lower bit after each falling edge.
- R4: `host_miso` is 0 whenever the synchronised chip-select is high.
- R5: `rx_is_cmd` is 1 for the first byte received after the counter was cleared and 0 for every later byte. Releasing chip-select at the end of a normal frame does not clear the counter.
- R6: A chip-select low period of at least MIN_CS_CYC system cycles (default 2) that ends with no rising serial-clock edge clears the byte counter.
- R7: A chip-select low pulse shorter than MIN_CS_CYC cycles is ignored. It does not clear the counter and does not produce a byte.
- R8: Releasing chip-select before the eighth rising edge of a byte discards the partial byte without a strobe. The next byte is assembled from fresh bits only.
- R9: The transmit byte is taken from `tx_byte` whenever no bit of the current byte has been clocked and the serial clock is low. It is frozen from the first rising edge of that byte onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip-select, active low |
| host_sck | input | 1 | Host serial clock, idles low |
| host_mosi | input | 1 | Serial data from the host |
| host_miso | output | 1 | Serial data to the host |
| tx_byte | input | 8 | Byte to transmit in the next byte time |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_byte | output | 8 | Last completed received byte |
| rx_is_cmd | output | 1 | 1 when `rx_byte` is the command byte |

## Verification
The assertions assume well-behaved host pins. The serial clock toggles only while chip-select is low. Every serial-clock level lasts several system cycles, so each edge survives the two-flop synchroniser as one distinct transition. Chip-select edges are at least six system cycles away from the nearest serial-clock edge. The stimulus keeps each serial-clock half period at four cycles and waits at least six cycles around every chip-select edge. The only sub-threshold pulse it applies is the single-cycle chip-select pulse used to exercise rejection.

// File: rtl/spi_rsync_pkg.sv
package spi_rsync_pkg;

    parameter int unsigned BYTE_W = 8;
    localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic {
        TAG_DATA = 1'b0,
        TAG_CMD  = 1'b1
    } byte_tag_e;

    typedef struct packed {
        logic [BYTE_W-1:0] value;
        byte_tag_e         tag;
    } rx_word_t;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic mosi;
    } host_pins_t;

    localparam host_pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0};

    function automatic logic went_high(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

    function automatic logic went_low(input logic now_v, input logic prev_v);
        return ~now_v & prev_v;
    endfunction

endpackage

// File: rtl/spr_sync.sv
module spr_sync
    import spi_rsync_pkg::*;
#(
    parameter int unsigned WIDTH = 3,
    parameter logic [WIDTH-1:0] IDLE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] now_q,
    output logic [WIDTH-1:0] prev_q
);

    logic [WIDTH-1:0] meta_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[g] <= IDLE[g];
                now_q[g]  <= IDLE[g];
                prev_q[g] <= IDLE[g];
            end else begin
                meta_q[g] <= raw_in[g];
                now_q[g]  <= meta_q[g];
                prev_q[g] <= now_q[g];
            end
        end
    end

endmodule

// File: rtl/spr_framer.sv
module spr_framer
    import spi_rsync_pkg::*;
#(
    parameter int unsigned MIN_CS_CYC = 2,
    parameter int unsigned CNT_W      = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_now,
    input  logic cs_prev,
    input  logic sck_now,
    input  logic sck_prev,
    input  logic byte_done,
    output logic frame_live,
    output logic sck_rise,
    output logic sck_fall,
    output logic first_byte,
    output logic reset_hit
);

    localparam int unsigned LO_W = $clog2(MIN_CS_CYC + 1);
    localparam logic [LO_W-1:0] LO_MAX = LO_W'(MIN_CS_CYC);
    localparam logic [LO_W-1:0] LO_ARM = LO_W'(MIN_CS_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [LO_W-1:0]  lo_cnt;
    logic [CNT_W-1:0] byte_cnt;
    logic             edge_seen;
    logic             released;

    assign frame_live = ~cs_now && (lo_cnt >= LO_ARM);
    assign sck_rise   = frame_live && went_high(sck_now, sck_prev);
    assign sck_fall   = frame_live && went_low(sck_now, sck_prev);
    assign released   = went_high(cs_now, cs_prev);
    assign reset_hit  = released && (lo_cnt >= LO_MAX) && !edge_seen;
    assign first_byte = (byte_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt    <= '0;
            edge_seen <= 1'b0;
            byte_cnt  <= '0;
        end else begin
            if (cs_now)
                lo_cnt <= '0;
            else if (lo_cnt != LO_MAX)
                lo_cnt <= lo_cnt + 1'b1;

            if (cs_now)
                edge_seen <= 1'b0;
            else if (sck_rise)
                edge_seen <= 1'b1;

            if (reset_hit)
                byte_cnt <= '0;
            else if (byte_done && byte_cnt != CNT_MAX)
                byte_cnt <= byte_cnt + 1'b1;
        end
    end

    // R6: the counter only returns to zero through a resync frame
    p_clear_by_frame_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(byte_cnt) != '0 && byte_cnt == '0) |-> $past(reset_hit));

endmodule

// File: rtl/spr_shifter.sv
module spr_shifter
    import spi_rsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_now,
    input  logic              sck_now,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_now,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_assembled,
    output logic              tx_msb
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    rx_sh;
    logic [BYTE_W-1:0]    tx_sh;

    assign byte_done    = sck_rise && (bit_cnt == LAST_BIT);
    assign rx_assembled = {rx_sh[BYTE_W-2:0], mosi_now};
    assign tx_msb       = tx_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else begin
            if (sck_fall && bit_cnt != '0)
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            else if (bit_cnt == '0 && !sck_now)
                tx_sh <= tx_byte;

            if (cs_now) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
            end else if (sck_rise) begin
                bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
                rx_sh   <= rx_assembled;
            end
        end
    end

    // R9: once a bit of the byte is clocked, the transmit shifter moves only on falling edges
    p_tx_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt != '0 && !sck_fall && !cs_now) |=> $stable(tx_sh));

endmodule

// File: rtl/spi_resync_slave.sv
module spi_resync_slave
    import spi_rsync_pkg::*;
#(
    parameter int unsigned MIN_CS_CYC = 2,
    parameter int unsigned CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs_n,
    input  logic              host_sck,
    input  logic              host_mosi,
    output logic              host_miso,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_is_cmd
);

    host_pins_t pins_raw, pins_now, pins_prev;
    logic frame_live, sck_rise, sck_fall, first_byte, reset_hit;
    logic byte_done, tx_msb;
    logic [BYTE_W-1:0] rx_assembled;
    rx_word_t out_q;
    logic valid_q;

    assign pins_raw = '{cs_n: host_cs_n, sck: host_sck, mosi: host_mosi};

    spr_sync #(.WIDTH(3), .IDLE(PINS_IDLE)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (pins_raw),
        .now_q  (pins_now),
        .prev_q (pins_prev)
    );

    spr_framer #(.MIN_CS_CYC(MIN_CS_CYC), .CNT_W(CNT_W)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .cs_now     (pins_now.cs_n),
        .cs_prev    (pins_prev.cs_n),
        .sck_now    (pins_now.sck),
        .sck_prev   (pins_prev.sck),
        .byte_done  (byte_done),
        .frame_live (frame_live),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .first_byte (first_byte),
        .reset_hit  (reset_hit)
    );

    spr_shifter u_shift (
        .clk          (clk),
        .rst          (rst),
        .cs_now       (pins_now.cs_n),
        .sck_now      (pins_now.sck),
        .sck_rise     (sck_rise),
        .sck_fall     (sck_fall),
        .mosi_now     (pins_now.mosi),
        .tx_byte      (tx_byte),
        .byte_done    (byte_done),
        .rx_assembled (rx_assembled),
        .tx_msb       (tx_msb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            out_q   <= '{value: '0, tag: TAG_DATA};
        end else begin
            valid_q <= byte_done;
            if (byte_done)
                out_q <= '{value: rx_assembled, tag: first_byte ? TAG_CMD : TAG_DATA};
        end
    end

    assign rx_valid  = valid_q;
    assign rx_byte   = out_q.value;
    assign rx_is_cmd = (out_q.tag == TAG_CMD);
    assign host_miso = ~pins_now.cs_n & tx_msb;

    // R2: a completed byte is strobed for a single cycle
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7: a byte can only come out of a qualified frame
    p_valid_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(frame_live));

    // R8: releasing chip-select never completes a byte
    p_no_byte_on_release_r8: assert property (@(posedge clk) disable iff (rst)
        (pins_now.cs_n && !pins_prev.cs_n) |=> !rx_valid);

endmodule

// File: tb/test_spi_resync_slave.sv
module test_spi_resync_slave;

    localparam int MIN_CS = 2;
    localparam int HALF   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic [7:0] tx_in = 8'h00;
    logic miso, rx_valid, rx_is_cmd;
    logic [7:0] rx_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_resync_slave i_spi_resync_slave (
        .clk       (clk),
        .rst       (rst),
        .host_cs_n (cs_n),
        .host_sck  (sck),
        .host_mosi (mosi),
        .host_miso (miso),
        .tx_byte   (tx_in),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rx_is_cmd (rx_is_cmd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: sample histories, integers for counters
    bit hc[4], hs[4], hd[4];
    int low_run, bits, acc, bytes_seen, txr;
    bit edges;
    bit e_valid, e_cmd, e_do;
    int e_data;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin hc[i] = 1; hs[i] = 0; hd[i] = 0; end
            low_run = 0; bits = 0; acc = 0; bytes_seen = 0; txr = 0; edges = 0;
            e_valid = 0; e_cmd = 0; e_data = 0; e_do = 0;
        end else begin
            bit c, cp, s, sp, d, live, rise, fall;
            for (int i = 3; i > 0; i--) begin hc[i] = hc[i-1]; hs[i] = hs[i-1]; hd[i] = hd[i-1]; end
            hc[0] = cs_n; hs[0] = sck; hd[0] = mosi;
            c = hc[2]; cp = hc[3]; s = hs[2]; sp = hs[3]; d = hd[2];
            live = !c && (low_run >= MIN_CS - 1);
            rise = live && s && !sp;
            fall = live && !s && sp;
            e_valid = 0;
            if (fall && bits != 0) txr = (txr << 1) & 8'hFF;
            else if (bits == 0 && !s) txr = tx_in;
            if (rise) begin
                edges = 1;
                acc = ((acc << 1) | d) & 8'hFF;
                bits++;
                if (bits == 8) begin
                    e_valid = 1; e_data = acc; e_cmd = (bytes_seen == 0);
                    if (bytes_seen < 255) bytes_seen++;
                    bits = 0;
                end
            end
            if (c && !cp && low_run >= MIN_CS && !edges) bytes_seen = 0;
            if (c) begin bits = 0; acc = 0; edges = 0; end
            low_run = c ? 0 : (low_run < MIN_CS ? low_run + 1 : low_run);
            e_do = !hc[1] && txr[7];
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    int got_q[$];
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(rx_valid == e_valid, "R2 valid", rx_valid, e_valid);
            if (e_valid) begin
                chk(rx_byte == e_data[7:0], "R2 data", rx_byte, e_data);
                chk(rx_is_cmd == e_cmd, "R5 tag", rx_is_cmd, e_cmd);
            end
            chk(miso == e_do, "R3/R4 miso", miso, e_do);
            if (rx_valid) got_q.push_back({23'd0, rx_is_cmd, rx_byte});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] seen);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            idle(HALF);
            seen[i] = miso;
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
        end
        mosi = 1'b0;
    endtask

    task automatic open_frame();
        cs_n = 1'b0; idle(8);
    endtask

    task automatic close_frame();
        idle(8); cs_n = 1'b1; idle(10);
    endtask

    task automatic expect_rx(input string req, input bit cmd, input logic [7:0] val);
        if (got_q.size() == 0) chk(0, req, -1, {cmd, val});
        else begin
            int g = got_q.pop_front();
            chk(g == {23'd0, cmd, val}, req, g, {cmd, val});
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] seen;
        idle(4);
        rst = 1'b0;
        idle(3);
        chk(rx_valid == 0, "R1 valid after reset", rx_valid, 0);
        chk(miso == 0, "R1 miso after reset", miso, 0);

        // R1/R5: first byte after reset is the command; R3 shifts tx MSB first
        tx_in = 8'h3C;
        open_frame();
        xfer(8'hA5, seen);
        idle(4);
        expect_rx("R5 first byte cmd", 1, 8'hA5);
        chk(seen == 8'h3C, "R3 miso byte0", seen, 8'h3C);
        // R9: new transmit byte picked up at the next byte boundary
        tx_in = 8'hC3;
        xfer(8'h5A, seen);
        idle(4);
        expect_rx("R5 second byte data", 0, 8'h5A);
        chk(seen == 8'hC3, "R9 miso byte1", seen, 8'hC3);
        close_frame();
        chk(miso == 0, "R4 miso idle", miso, 0);

        // R5: counter persists over a normal frame end
        tx_in = 8'h81;
        open_frame();
        xfer(8'h11, seen);
        close_frame();
        expect_rx("R5 persists", 0, 8'h11);
        chk(seen == 8'h81, "R3 miso 81", seen, 8'h81);

        // R7: one-cycle pulse neither clears nor frames
        cs_n = 1'b0; idle(1); cs_n = 1'b1; idle(10);
        chk(got_q.size() == 0, "R7 no byte", got_q.size(), 0);
        open_frame();
        xfer(8'h22, seen);
        close_frame();
        expect_rx("R7 short pulse ignored", 0, 8'h22);

        // R6: shortest qualifying resync frame clears the counter
        cs_n = 1'b0; idle(MIN_CS); cs_n = 1'b1; idle(10);
        open_frame();
        xfer(8'h96, seen);
        xfer(8'h69, seen);
        close_frame();
        expect_rx("R6 cmd after resync", 1, 8'h96);
        expect_rx("R6 then data", 0, 8'h69);

        // R8: partial byte discarded
        open_frame();
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b1; idle(HALF); sck = 1'b1; idle(HALF); sck = 1'b0;
        end
        mosi = 1'b0;
        close_frame();
        chk(got_q.size() == 0, "R8 no strobe on abort", got_q.size(), 0);
        open_frame();
        xfer(8'h07, seen);
        close_frame();
        expect_rx("R8 fresh byte", 0, 8'h07);

        // R6: longer resync frame
        cs_n = 1'b0; idle(12); cs_n = 1'b1; idle(10);
        tx_in = 8'hF0;
        open_frame();
        xfer(8'hE1, seen);
        close_frame();
        expect_rx("R6 long resync", 1, 8'hE1);
        chk(seen == 8'hF0, "R3 miso F0", seen, 8'hF0);
        chk(got_q.size() == 0, "R2 no extra bytes", got_q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule